// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the write port of a word-wide NOR-style flash model. It decodes the command words written to it and decides which source drives reads: the memory array, the status byte, the identifier space or the query table. It also runs program, erase, lock and one-time-programmable jobs on a simple engine. The engine is a down-counter that stays busy for a set number of cycles. A host issues a command by pulsing the write strobe for one clock with the command in the low byte of the data word. Two-cycle commands take a setup word first and then a second word that carries the target address, plus either the data or a confirm byte.

A running job can be paused with a suspend command and continued with a resume command. While it is paused, the host may change the read mode, for example to fetch array data. A bad second word after an erase or lock setup leaves a sticky sequence-error code in the status byte, which only the clear command removes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset pulse on `rst`, the outputs read as follows: `rd_mode` is 0 (array), `status` is 0x80 and `job_req` is 0. Any job in flight is abandoned, so `status[7]` stays 1 afterwards.
- R2: When no job is pending, a write of 0xFF, 0x70, 0x90 or 0x98 in the low byte sets `rd_mode` to 0 (array), 1 (status), 2 (identifier) or 3 (query). The new mode is visible in the cycle after the write.
- R3: A write of 0x40 or 0x10 is a program setup and sets `rd_mode` to 1. The next write launches a job. In the cycle after that write, `job_req` is high for one cycle, `job_kind` is 0, and `job_addr`/`job_data` hold that write's address and data.
- R4: `status[7]` reads 0 for exactly JOB_CYCLES cycles of unsuspended running time after a launch, counting the cycle in which `job_req` is high. It reads 1 at all other times.
- R5: A write of 0x20 followed by a write whose low byte is 0xD0 launches a job with `job_kind` 1 at the confirm's address. Any other second low byte launches nothing and sets `status[5]` and `status[4]`, so the status reads 0xB0.
- R6: A write of 0x60 followed by a low byte of 0x01, 0xD0 or 0x2F launches `job_kind` 2 with that write's data. Any other second byte gives the sequence-error code of R5. A write of 0xC0 followed by any word launches `job_kind` 3.
- R7: A write of 0xB0 during a running job pauses it. `status[7]` becomes 1, and either `status[6]` (erase job) or `status[2]` (any other job) becomes 1. The remaining time is frozen until a write of 0xD0 resumes the job. The resume also sets `rd_mode` to 1.
- R8: While a job is suspended, the read-mode commands of R2 still change `rd_mode`. Setup commands (0x40, 0x10, 0x20, 0x60, 0xC0) are ignored.
- R9: While a job is running, every write other than 0xB0 and 0x70 is ignored. No setup is entered and `rd_mode` is unchanged.
- R10: A write of 0x50 clears `status[5:4]` without changing `rd_mode`. Until then, those bits stay set across any other commands.
- R11: When no job is pending, a low byte that is none of the listed commands leaves `rd_mode`, `status` and `job_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command |
| rd_mode | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte: 7 ready, 6 erase suspended, 5/4 sequence error, 2 other suspended |
| job_req | output | 1 | One-cycle job launch pulse |
| job_kind | output | 2 | 0 program, 1 erase, 2 lock, 3 one-time-programmable |
| job_addr | output | ADDR_W | Address of the launched job |
| job_data | output | DATA_W | Data of the launched job |

## Verification
A stale setup state shows up on the very next write. The following word either launches a job or raises the error code, where it should have done nothing, so a wrong `job_req` or `status` appears one cycle later. A wrong suspend flag or a counter that fails to freeze changes the total number of busy cycles by at least one, and the bench compares that total against JOB_CYCLES. A wrong read mode is visible on `rd_mode` in the cycle after the write that set it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    JK_PROG  = 2'd0,
    JK_ERASE = 2'd1,
    JK_LOCK  = 2'd2,
    JK_OTP   = 2'd3
  } job_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_ERASE,
    SQ_LOCK,
    SQ_OTP
  } seq_state_e;

  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_PROG_ALT = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_OTP      = 8'hC0;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LK_SET   = 8'h01;
  localparam logic [7:0] OP_LK_DOWN  = 8'h2F;

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] op,
  input  logic       eng_run,
  input  logic       eng_susp,
  output logic [1:0] rd_mode,
  output logic       launch,
  output job_kind_e  launch_kind,
  output logic       suspend_cmd,
  output logic       resume_cmd,
  output logic       clear_cmd,
  output logic       seq_err
);

  seq_state_e state_q, state_d;
  rd_mode_e   mode_q, mode_d;

  // Recognise a read-source command
  function automatic logic is_mode_op(input logic [7:0] c);
    return (c == OP_ARRAY) || (c == OP_STATUS) || (c == OP_IDENT) || (c == OP_QUERY);
  endfunction

  function automatic rd_mode_e mode_of(input logic [7:0] c);
    case (c)
      OP_STATUS: return RM_STATUS;
      OP_IDENT:  return RM_IDENT;
      OP_QUERY:  return RM_QUERY;
      default:   return RM_ARRAY;
    endcase
  endfunction

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    launch      = 1'b0;
    launch_kind = JK_PROG;
    suspend_cmd = 1'b0;
    resume_cmd  = 1'b0;
    clear_cmd   = 1'b0;
    seq_err     = 1'b0;
    if (wr_en) begin
      case (state_q)
        SQ_IDLE: begin
          if (eng_run) begin
            // Only pause and status view are honoured while running
            if (op == OP_SUSPEND)     suspend_cmd = 1'b1;
            else if (op == OP_STATUS) mode_d = RM_STATUS;
          end else if (eng_susp) begin
            if (is_mode_op(op))        mode_d = mode_of(op);
            else if (op == OP_CONFIRM) begin
              resume_cmd = 1'b1;
              mode_d     = RM_STATUS;
            end else if (op == OP_CLEAR) clear_cmd = 1'b1;
          end else begin
            if (is_mode_op(op))     mode_d = mode_of(op);
            else if (op == OP_CLEAR) clear_cmd = 1'b1;
            else if (op == OP_PROG || op == OP_PROG_ALT) begin
              state_d = SQ_PROG;
              mode_d  = RM_STATUS;
            end else if (op == OP_ERASE) begin
              state_d = SQ_ERASE;
              mode_d  = RM_STATUS;
            end else if (op == OP_LOCK) begin
              state_d = SQ_LOCK;
              mode_d  = RM_STATUS;
            end else if (op == OP_OTP) begin
              state_d = SQ_OTP;
              mode_d  = RM_STATUS;
            end
          end
        end
        SQ_PROG: begin
          launch      = 1'b1;
          launch_kind = JK_PROG;
          state_d     = SQ_IDLE;
        end
        SQ_ERASE: begin
          if (op == OP_CONFIRM) begin
            launch      = 1'b1;
            launch_kind = JK_ERASE;
          end else begin
            seq_err = 1'b1;
          end
          state_d = SQ_IDLE;
        end
        SQ_LOCK: begin
          if (op == OP_LK_SET || op == OP_CONFIRM || op == OP_LK_DOWN) begin
            launch      = 1'b1;
            launch_kind = JK_LOCK;
          end else begin
            seq_err = 1'b1;
          end
          state_d = SQ_IDLE;
        end
        SQ_OTP: begin
          launch      = 1'b1;
          launch_kind = JK_OTP;
          state_d     = SQ_IDLE;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      mode_q  <= RM_ARRAY;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign rd_mode = mode_q;

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int JOB_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  job_kind_e         launch_kind,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_data,
  input  logic              suspend_cmd,
  input  logic              resume_cmd,
  output logic              eng_run,
  output logic              eng_susp,
  output job_kind_e         eng_kind,
  output logic              job_req,
  output logic [ADDR_W-1:0] job_addr,
  output logic [DATA_W-1:0] job_data
);

  localparam int CNT_W = $clog2(JOB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(JOB_CYCLES);

  logic [CNT_W-1:0]  cnt_q;
  logic              susp_q;
  logic              req_q;
  job_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign eng_run  = (cnt_q != '0) && !susp_q;
  assign eng_susp = susp_q;
  assign eng_kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= JK_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q <= launch;
      if (launch) begin
        cnt_q  <= CNT_LOAD;
        kind_q <= launch_kind;
        addr_q <= launch_addr;
        data_q <= launch_data;
      end else if (eng_run) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (suspend_cmd)     susp_q <= 1'b1;
      else if (resume_cmd) susp_q <= 1'b0;
    end
  end

  assign job_req  = req_q;
  assign job_addr = addr_q;
  assign job_data = data_q;

endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seq_err,
  input  logic       clear_cmd,
  input  logic       eng_run,
  input  logic       eng_susp,
  input  job_kind_e  eng_kind,
  output logic [7:0] status
);

  logic [1:0] err_q;   // sticky sequence-error pair, bits 5 and 4

  always_ff @(posedge clk) begin
    if (rst)            err_q <= 2'b00;
    else if (seq_err)   err_q <= 2'b11;
    else if (clear_cmd) err_q <= 2'b00;
  end

  always_comb begin
    status    = 8'h00;
    status[7] = !eng_run;
    status[6] = eng_susp && (eng_kind == JK_ERASE);
    status[5] = err_q[1];
    status[4] = err_q[0];
    status[2] = eng_susp && (eng_kind != JK_ERASE);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int JOB_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status,
  output logic              job_req,
  output logic [1:0]        job_kind,
  output logic [ADDR_W-1:0] job_addr,
  output logic [DATA_W-1:0] job_data
);

  logic      launch, suspend_cmd, resume_cmd, clear_cmd, seq_err;
  logic      eng_run, eng_susp;
  job_kind_e launch_kind, eng_kind;

  fcs_decoder u_dec (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .op          (wr_data[7:0]),
    .eng_run     (eng_run),
    .eng_susp    (eng_susp),
    .rd_mode     (rd_mode),
    .launch      (launch),
    .launch_kind (launch_kind),
    .suspend_cmd (suspend_cmd),
    .resume_cmd  (resume_cmd),
    .clear_cmd   (clear_cmd),
    .seq_err     (seq_err)
  );

  fcs_engine #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .JOB_CYCLES (JOB_CYCLES)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_kind (launch_kind),
    .launch_addr (wr_addr),
    .launch_data (wr_data),
    .suspend_cmd (suspend_cmd),
    .resume_cmd  (resume_cmd),
    .eng_run     (eng_run),
    .eng_susp    (eng_susp),
    .eng_kind    (eng_kind),
    .job_req     (job_req),
    .job_addr    (job_addr),
    .job_data    (job_data)
  );

  fcs_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .seq_err   (seq_err),
    .clear_cmd (clear_cmd),
    .eng_run   (eng_run),
    .eng_susp  (eng_susp),
    .eng_kind  (eng_kind),
    .status    (status)
  );

  assign job_kind = eng_kind;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        rd_mode,
  input logic [7:0]        status,
  input logic              job_req
);

  // R1: first cycle out of reset shows array mode and an idle status
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_mode == 2'd0 && status == 8'h80 && !job_req));

  // R3: a launch is a single-cycle pulse
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    job_req |=> !job_req);

  // R4: a launched job is busy in its launch cycle
  a_r4_busy_on_launch: assert property (@(posedge clk) disable iff (rst)
    job_req |-> !status[7]);

  // R5: the sequence-error pair always rises together
  a_r5_err_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> status[4]);

  // R7: at most one suspend flag, and only while ready reads 1
  a_r7_susp_flags: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[6], status[2]}) && ((status[6] || status[2]) -> status[7]));

  // R9: no launch can follow a running cycle
  a_r9_no_launch_busy: assert property (@(posedge clk) disable iff (rst)
    !status[7] |=> !job_req);

  // R10: error bits are sticky until a clear command
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !(wr_en && wr_data[7:0] == 8'h50)) |=> status[5]);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_mode (rd_mode),
  .status  (status),
  .job_req (job_req)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int JOBN   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_mode;
  logic [7:0]        status;
  logic              job_req;
  logic [1:0]        job_kind;
  logic [ADDR_W-1:0] job_addr;
  logic [DATA_W-1:0] job_data;

  int n_chk = 0;
  int n_fail = 0;
  int busy_n = 0;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .JOB_CYCLES(JOBN)) i_flash_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_mode(rd_mode), .status(status), .job_req(job_req), .job_kind(job_kind),
    .job_addr(job_addr), .job_data(job_data)
  );

  always #2 clk = ~clk;

  // vector: {cmd[23:16], mode[15:12], status[11:4], req tag[3:0]}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 4'd0, 8'h80, 4'd2},   // R2 array
    {8'h70, 4'd1, 8'h80, 4'd2},   // R2 status
    {8'h90, 4'd2, 8'h80, 4'd2},   // R2 identifier
    {8'h98, 4'd3, 8'h80, 4'd2},   // R2 query
    {8'hAB, 4'd3, 8'h80, 4'd11},  // R11 unknown ignored
    {8'h20, 4'd1, 8'h80, 4'd5},   // R5 erase setup
    {8'h33, 4'd1, 8'hB0, 4'd5},   // R5 bad confirm
    {8'hFF, 4'd0, 8'hB0, 4'd10},  // R10 sticky error
    {8'h50, 4'd0, 8'h80, 4'd10},  // R10 clear keeps mode
    {8'h60, 4'd1, 8'h80, 4'd6},   // R6 lock setup
    {8'h77, 4'd1, 8'hB0, 4'd6},   // R6 bad lock byte
    {8'h50, 4'd1, 8'h80, 4'd10}   // R10 clear
  };

  task automatic chk(input logic ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the falling edge after capture
  task automatic wr(input logic [15:0] d, input logic [19:0] a);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    if (!status[7]) busy_n++;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 100 && !status[7]; g++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(rd_mode == 2'd0, "R1", "mode", rd_mode, 0);
    chk(status == 8'h80, "R1", "status", status, 8'h80);
    chk(job_req == 1'b0, "R1", "job_req", job_req, 0);

    for (int i = 0; i < NV; i++) begin
      wr({8'h00, VEC[i][23:16]}, 20'h0);
      chk(rd_mode == VEC[i][13:12], $sformatf("R%0d v%0d", VEC[i][3:0], i), "mode",
          rd_mode, VEC[i][13:12]);
      chk(status == VEC[i][11:4], $sformatf("R%0d v%0d", VEC[i][3:0], i), "status",
          status, VEC[i][11:4]);
      chk(!job_req, $sformatf("R%0d v%0d", VEC[i][3:0], i), "job_req", job_req, 0);
    end

    // R3 program launch, R4 busy length
    wr(16'h0040, 20'h0);
    wr(16'h1234, 20'h00155);
    chk(job_req, "R3", "job_req", job_req, 1);
    chk(job_kind == 2'd0, "R3", "kind", job_kind, 0);
    chk(job_addr == 20'h00155, "R3", "addr", job_addr, 20'h155);
    chk(job_data == 16'h1234, "R3", "data", job_data, 16'h1234);
    chk(rd_mode == 2'd1, "R3", "mode", rd_mode, 1);
    busy_n = status[7] ? 0 : 1;
    wait_ready();
    chk(busy_n == JOBN, "R4", "busy cycles", busy_n, JOBN);
    chk(!job_req, "R3", "pulse width", job_req, 0);

    // R3 alias, R9 writes ignored while running
    wr(16'h0010, 20'h0);
    wr(16'hBEEF, 20'h0ABCD);
    chk(job_req && job_data == 16'hBEEF, "R3", "alias data", job_data, 16'hBEEF);
    wr(16'h0040, 20'h0);
    chk(!job_req && !status[7], "R9", "setup while busy", status, 8'h00);
    wr(16'h0090, 20'h0);
    chk(rd_mode == 2'd1, "R9", "mode while busy", rd_mode, 1);
    wait_ready();
    wr(16'h5634, 20'h00001);
    chk(!job_req && status == 8'h80, "R9", "no stale setup", {job_req, status}, 8'h80);

    // R5 erase, R7 suspend/resume, R8 suspended commands
    wr(16'h0020, 20'h0);
    wr(16'h00D0, 20'h00800);
    chk(job_req && job_kind == 2'd1, "R5", "erase kind", job_kind, 1);
    chk(job_addr == 20'h00800, "R5", "erase addr", job_addr, 20'h800);
    busy_n = status[7] ? 0 : 1;
    step(); step();
    wr(16'h00B0, 20'h0);
    chk(status == 8'hC0, "R7", "erase suspended", status, 8'hC0);
    wr(16'h00FF, 20'h0);
    chk(rd_mode == 2'd0, "R8", "array in suspend", rd_mode, 0);
    wr(16'h0040, 20'h0);
    chk(rd_mode == 2'd0 && status == 8'hC0, "R8", "setup ignored", status, 8'hC0);
    repeat (4) step();
    chk(status == 8'hC0, "R7", "frozen", status, 8'hC0);
    wr(16'h0090, 20'h0);
    chk(rd_mode == 2'd2, "R8", "ident in suspend", rd_mode, 2);
    wr(16'h00D0, 20'h0);
    chk(!job_req, "R8", "resume not data", job_req, 0);
    chk(rd_mode == 2'd1 && !status[7], "R7", "resumed", status, 8'h00);
    if (!status[7]) busy_n++;
    wait_ready();
    chk(busy_n == JOBN, "R7", "busy total over suspend", busy_n, JOBN);

    // R7 program suspend flag
    wr(16'h0040, 20'h0);
    wr(16'h0001, 20'h00002);
    wr(16'h00B0, 20'h0);
    chk(status == 8'h84, "R7", "program suspended", status, 8'h84);
    wr(16'h00D0, 20'h0);
    chk(status == 8'h00, "R7", "program resumed", status, 8'h00);
    wait_ready();

    // R6 lock and one-time-programmable
    wr(16'h0060, 20'h0);
    wr(16'h002F, 20'h08000);
    chk(job_req && job_kind == 2'd2 && job_data == 16'h002F, "R6", "lock-down",
        job_data, 16'h2F);
    wait_ready();
    wr(16'h0060, 20'h0);
    wr(16'h0001, 20'h10000);
    chk(job_req && job_kind == 2'd2 && job_addr == 20'h10000, "R6", "lock", job_addr,
        20'h10000);
    wait_ready();
    wr(16'h00C0, 20'h0);
    wr(16'hFFFD, 20'h00080);
    chk(job_req && job_kind == 2'd3 && job_data == 16'hFFFD, "R6", "otp", job_data,
        16'hFFFD);
    wait_ready();

    // R1 reset aborts a running job
    wr(16'h0020, 20'h0);
    wr(16'h00D0, 20'h0);
    step();
    do_reset();
    chk(rd_mode == 2'd0 && status == 8'h80, "R1", "reset mid-job", status, 8'h80);
    step(); step();
    chk(status == 8'h80 && !job_req, "R1", "job abandoned", status, 8'h80);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule